// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the stack-frame work of subroutine calls, indirect calls, software-interrupt entry and subroutine return. A request brings in the current stack pointer, frame pointer, program counter and a branch target, plus an operation code. The block then walks through a short fixed list of word accesses on a memory port with a ready handshake. When the list is finished it reports the new stack pointer, frame pointer and program counter, together with a one-cycle done pulse.

Each frame occupies three words below the caller's stack pointer. The highest word is a static-chain slot that is reserved but never written. The middle word holds the return address, and the lowest word holds the caller's frame pointer. After a call, the frame pointer and the stack pointer both point at the lowest word. A return rebuilds the caller's state from the frame pointer alone. A misaligned base pointer is detected when the request is accepted. The block then raises a fault pulse and makes no memory access.

Top module: `frame_seq`

## Requirements
- R1: After reset, busy, done, fault, mem_req and mem_we are low and sp_out, fp_out and pc_out are zero.
- R2: Operation code 0 (absolute call) writes pc_in+6 to address sp_in-8 and then writes fp_in to address sp_in-12. No access is made to sp_in-4.
- R3: Operation code 1 (register call) makes the same two writes, but the return address is pc_in+2.
- R4: Operation code 2 (software interrupt) makes the same two writes with return address pc_in+6. Its new PC is tgt_in, which the caller supplies from the handler register.
- R5: When a call-type sequence completes, sp_out and fp_out both equal sp_in-12 and pc_out equals tgt_in.
- R6: Operation code 3 (return) reads address fp_in and then address fp_in+4. On completion, fp_out is the first word read, pc_out is the second word read, and sp_out is fp_in+12.
- R7: While mem_req is high and mem_ready is low, the request, address, write flag and write data hold steady. Each access completes only in a cycle where mem_ready is high.
- R8: A request raised while busy is high is ignored. The sequence in progress completes unchanged, and no further sequence starts.
- R9: If the base pointer (fp_in for a return, sp_in otherwise) has either of its two low bits set, fault pulses for one cycle, no memory access is made, done does not pulse, and the outputs keep their previous values. The low bits of the pointer that is not used as the base are not checked.
- R10: The outputs change only in the cycle in which done is high.
- R11: done lasts exactly one cycle, and every memory address issued is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a sequence (accepted only while idle) |
| req_op | input | 2 | 0 absolute call, 1 register call, 2 software interrupt, 3 return |
| sp_in | input | 32 | Current stack pointer |
| fp_in | input | 32 | Current frame pointer |
| pc_in | input | 32 | Address of the instruction making the request |
| tgt_in | input | 32 | Target address for call-type operations |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse; results are valid |
| fault | output | 1 | One-cycle alignment fault pulse |
| sp_out | output | 32 | New stack pointer |
| fp_out | output | 32 | New frame pointer |
| pc_out | output | 32 | New program counter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Access completes at this clock edge |

## Verification
The checker enforces, on every cycle, that stalled requests hold steady, that addresses are aligned, that done and fault are single pulses that exclude each other, and that the outputs move only with done. It does not know the operation, so it cannot check slot contents. The order and values of the frame accesses, the return-address offsets, the rebuilt pointers, the rejection of requests made while busy, and the choice of base pointer for the alignment test are shown only by the bench's sweeps. These sweeps run every operation across several pointers and ready delays, and compare the results against a behavioural memory.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

   typedef enum logic [1:0] {
      FOP_CALL_ABS = 2'd0,
      FOP_CALL_REG = 2'd1,
      FOP_SWI      = 2'd2,
      FOP_RET      = 2'd3
   } fop_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACC0,
      ST_ACC1,
      ST_DONE,
      ST_FAULT
   } fst_e;

   function automatic logic fop_is_ret(input fop_e op);
      return op == FOP_RET;
   endfunction

endpackage

// File: rtl/frame_seq_step.sv
// Combinational description of one frame access: where, what, and which way.
module frame_seq_step
   import frame_seq_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int LONG_LEN  = 6,
   parameter int SHORT_LEN = 2
) (
   input  fop_e          op,
   input  logic          step,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] fp,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] wdata,
   output logic          we
);
   localparam int SLOT = DW / 8;
   localparam logic [AW-1:0] SLOT2 = AW'(2 * SLOT);
   localparam logic [AW-1:0] SLOT3 = AW'(3 * SLOT);

   logic [AW-1:0] ret_addr;

   always_comb begin
      ret_addr = pc + ((op == FOP_CALL_REG) ? AW'(SHORT_LEN) : AW'(LONG_LEN));
      if (fop_is_ret(op)) begin
         we    = 1'b0;
         wdata = '0;
         addr  = step ? base + AW'(SLOT) : base;
      end else begin
         we    = 1'b1;
         addr  = step ? base - SLOT3 : base - SLOT2;
         wdata = step ? DW'(fp) : DW'(ret_addr);
      end
   end

endmodule

// File: rtl/frame_seq_ctl.sv
// Sequencing state machine: accept, two handshaked accesses, then done or fault.
module frame_seq_ctl
   import frame_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic misalign,
   input  logic mem_ready,
   output fst_e state,
   output logic busy,
   output logic mem_req,
   output logic step,
   output logic fire,
   output logic done,
   output logic fault
);
   fst_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (start) nxt = misalign ? ST_FAULT : ST_ACC0;
         ST_ACC0:  if (mem_ready) nxt = ST_ACC1;
         ST_ACC1:  if (mem_ready) nxt = ST_DONE;
         ST_DONE:  nxt = ST_IDLE;
         ST_FAULT: nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign busy    = state != ST_IDLE;
   assign mem_req = (state == ST_ACC0) || (state == ST_ACC1);
   assign step    = state == ST_ACC1;
   assign fire    = mem_req && mem_ready;
   assign done    = state == ST_DONE;
   assign fault   = state == ST_FAULT;

endmodule

// File: rtl/frame_seq.sv
module frame_seq
   import frame_seq_pkg::*;
#(
   parameter int AW          = 32,
   parameter int DW          = 32,
   parameter bit ALIGN_CHECK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] sp_in,
   input  logic [AW-1:0] fp_in,
   input  logic [AW-1:0] pc_in,
   input  logic [AW-1:0] tgt_in,
   output logic          busy,
   output logic          done,
   output logic          fault,
   output logic [AW-1:0] sp_out,
   output logic [AW-1:0] fp_out,
   output logic [AW-1:0] pc_out,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ready
);
   localparam int SLOT       = DW / 8;
   localparam int ALIGN_BITS = $clog2(SLOT);
   localparam logic [AW-1:0] FRAME = AW'(3 * SLOT);

   initial begin
      if (DW % 8 != 0 || DW < 16) $error("frame_seq: DW must be a byte multiple of at least 16");
      if (AW > DW)                $error("frame_seq: AW must not exceed DW");
      if (SLOT != (1 << ALIGN_BITS)) $error("frame_seq: DW/8 must be a power of two");
   end

   fop_e          op_in, op_q;
   fst_e          state;
   logic          accept, misalign, step, fire, step_we;
   logic [AW-1:0] base_in, base_q, pc_q, fp_q, tgt_q;
   logic [DW-1:0] rd0_q;

   assign op_in   = fop_e'(req_op);
   assign base_in = fop_is_ret(op_in) ? fp_in : sp_in;
   assign accept  = req_valid && !busy;

   generate
      if (ALIGN_CHECK) begin : g_align
         assign misalign = |base_in[ALIGN_BITS-1:0];
      end else begin : g_noalign
         assign misalign = 1'b0;
      end
   endgenerate

   frame_seq_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .misalign (misalign),
      .mem_ready(mem_ready),
      .state    (state),
      .busy     (busy),
      .mem_req  (mem_req),
      .step     (step),
      .fire     (fire),
      .done     (done),
      .fault    (fault)
   );

   frame_seq_step #(.AW(AW), .DW(DW)) u_step (
      .op   (op_q),
      .step (step),
      .base (base_q),
      .pc   (pc_q),
      .fp   (fp_q),
      .addr (mem_addr),
      .wdata(mem_wdata),
      .we   (step_we)
   );

   assign mem_we = mem_req && step_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= FOP_CALL_ABS;
         base_q <= '0;
         pc_q   <= '0;
         fp_q   <= '0;
         tgt_q  <= '0;
         rd0_q  <= '0;
         sp_out <= '0;
         fp_out <= '0;
         pc_out <= '0;
      end else begin
         if (accept) begin
            op_q   <= op_in;
            base_q <= base_in;
            pc_q   <= pc_in;
            fp_q   <= fp_in;
            tgt_q  <= tgt_in;
         end
         if (fire && !step) rd0_q <= mem_rdata;
         if (fire && step) begin
            if (fop_is_ret(op_q)) begin
               sp_out <= base_q + FRAME;
               fp_out <= AW'(rd0_q);
               pc_out <= AW'(mem_rdata);
            end else begin
               sp_out <= base_q - FRAME;
               fp_out <= base_q - FRAME;
               pc_out <= tgt_q;
            end
         end
      end
   end

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          fault,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_ready,
   input logic [AW-1:0] sp_out,
   input logic [AW-1:0] fp_out,
   input logic [AW-1:0] pc_out
);
   localparam int ALIGN_BITS = $clog2(DW / 8);

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R7
   req_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy && !done && !fault);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[ALIGN_BITS-1:0] == '0);

   // R9
   fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault && !done && !mem_req);

   // R10
   out_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(sp_out) && $stable(fp_out) && $stable(pc_out)) |-> done);

endmodule

bind frame_seq frame_seq_chk #(.AW(AW), .DW(DW)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .fault    (fault),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .mem_ready(mem_ready),
   .sp_out   (sp_out),
   .fp_out   (fp_out),
   .pc_out   (pc_out)
);

// File: tb/frame_seq_tb.sv
module frame_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd0;
   logic [31:0] sp_in = '0, fp_in = '0, pc_in = '0, tgt_in = '0;
   logic        busy, done, fault, mem_req, mem_we;
   logic [31:0] sp_out, fp_out, pc_out, mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   logic [31:0] mem [0:255];
   logic [31:0] acc_addr [0:3];
   logic [31:0] acc_data [0:3];
   logic        acc_we [0:3];
   int          acc_n = 0;
   int          dly = 0;
   int          wcnt = 0;

   always #10 clk = ~clk;

   frame_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .sp_in(sp_in), .fp_in(fp_in), .pc_in(pc_in), .tgt_in(tgt_in),
      .busy(busy), .done(done), .fault(fault),
      .sp_out(sp_out), .fp_out(fp_out), .pc_out(pc_out),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   // Behavioural memory: answers after dly idle cycles, ready lasts one cycle.
   always @(negedge clk) begin
      if (mem_ready) begin
         mem_ready <= 1'b0;
      end else if (mem_req) begin
         if (wcnt >= dly) begin
            mem_ready <= 1'b1;
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            if (acc_n < 4) begin
               acc_addr[acc_n] <= mem_addr;
               acc_we[acc_n]   <= mem_we;
               acc_data[acc_n] <= mem_we ? mem_wdata : mem[mem_addr[9:2]];
            end
            acc_n <= acc_n + 1;
            wcnt  <= 0;
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected<=100000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Issue one request, optionally poking req_valid while busy; wait for done or fault.
   task automatic issue(input logic [1:0] op, input logic [31:0] sp, fp, pc, tgt,
                        input bit poke, output bit saw_done, output bit saw_fault);
      int n;
      acc_n = 0;
      @(negedge clk); #1;
      req_op = op; sp_in = sp; fp_in = fp; pc_in = pc; tgt_in = tgt; req_valid = 1'b1;
      @(negedge clk); #1;
      req_valid = 1'b0;
      if (poke) begin
         req_op = ~op; sp_in = sp + 32'h40; fp_in = fp + 32'h40; req_valid = 1'b1;
      end
      n = 0;
      while (!(done || fault) && n < 100) begin
         @(negedge clk); #1;
         n++;
      end
      req_valid = 1'b0;
      saw_done  = done;
      saw_fault = fault;
      @(negedge clk); #1;
      check(!done, "R11 done single cycle", {31'd0, done}, 32'd0);
   endtask

   task automatic run_call(input logic [1:0] op, input logic [31:0] sp, fp, pc, tgt, input bit poke);
      bit d, f;
      logic [31:0] ra;
      ra = pc + ((op == 2'd1) ? 32'd2 : 32'd6);
      issue(op, sp, fp, pc, tgt, poke, d, f);
      check(d && !f, "R5 call completes", {30'd0, d, f}, 32'd2);
      check(acc_n == 2, "R2 two frame writes, chain slot untouched", acc_n, 32'd2);
      check(acc_we[0] && acc_addr[0] == sp - 32'd8, "R2 return slot address", acc_addr[0], sp - 32'd8);
      if (op == 2'd1)
         check(acc_data[0] == ra, "R3 register call return address", acc_data[0], ra);
      else if (op == 2'd2)
         check(acc_data[0] == ra, "R4 interrupt return address", acc_data[0], ra);
      else
         check(acc_data[0] == ra, "R2 absolute call return address", acc_data[0], ra);
      check(acc_we[1] && acc_addr[1] == sp - 32'd12, "R2 saved frame slot address", acc_addr[1], sp - 32'd12);
      check(acc_data[1] == fp, "R2 saved frame pointer", acc_data[1], fp);
      check(sp_out == sp - 32'd12, "R5 new stack pointer", sp_out, sp - 32'd12);
      check(fp_out == sp - 32'd12, "R5 new frame pointer", fp_out, sp - 32'd12);
      if (op == 2'd2) check(pc_out == tgt, "R4 handler target", pc_out, tgt);
      else            check(pc_out == tgt, "R5 call target", pc_out, tgt);
   endtask

   task automatic run_ret(input logic [31:0] sp, fp, input logic [31:0] old_fp, ret_pc, input bit poke);
      bit d, f;
      mem[fp[9:2]]          = old_fp;
      mem[fp[9:2] + 8'd1]   = ret_pc;
      issue(2'd3, sp, fp, 32'h0, 32'h0, poke, d, f);
      check(d && !f, "R6 return completes", {30'd0, d, f}, 32'd2);
      check(acc_n == 2, "R6 two frame reads", acc_n, 32'd2);
      check(!acc_we[0] && acc_addr[0] == fp, "R6 first read address", acc_addr[0], fp);
      check(!acc_we[1] && acc_addr[1] == fp + 32'd4, "R6 second read address", acc_addr[1], fp + 32'd4);
      check(fp_out == old_fp, "R6 restored frame pointer", fp_out, old_fp);
      check(pc_out == ret_pc, "R6 return address", pc_out, ret_pc);
      check(sp_out == fp + 32'd12, "R6 restored stack pointer", sp_out, fp + 32'd12);
   endtask

   task automatic run_fault(input logic [1:0] op, input logic [31:0] sp, fp);
      bit d, f;
      logic [31:0] s0, f0, p0;
      s0 = sp_out; f0 = fp_out; p0 = pc_out;
      issue(op, sp, fp, 32'h1234, 32'h5678, 1'b0, d, f);
      check(f && !d, "R9 fault pulse without done", {30'd0, d, f}, 32'd1);
      check(acc_n == 0, "R9 no memory access on fault", acc_n, 32'd0);
      check(sp_out == s0 && fp_out == f0 && pc_out == p0, "R9 outputs kept", sp_out, s0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
      repeat (3) @(negedge clk);
      #1;
      check(!busy && !done && !fault && !mem_req && !mem_we, "R1 reset controls",
            {27'd0, busy, done, fault, mem_req, mem_we}, 32'd0);
      check(sp_out == 0 && fp_out == 0 && pc_out == 0, "R1 reset outputs", sp_out | fp_out | pc_out, 32'd0);
      rst_n = 1'b1;

      for (int d = 0; d < 3; d++) begin
         dly = d;
         for (int k = 0; k < 4; k++) begin
            for (int op = 0; op < 3; op++)
               run_call(op[1:0], 32'h200 + k * 32'h40, 32'h300 + k * 32'h10,
                        32'h1000 + k * 6 + op * 2, 32'hA000 + k * 4 + op * 32'h100, 1'b0);
            run_ret(32'h111 + k, 32'h300 + k * 32'h10, 32'hF000_0100 + k * 4, 32'h0000_8000 + k * 2, 1'b0);
         end
      end

      // R8: requests raised while busy are ignored
      dly = 2;
      run_call(2'd0, 32'h280, 32'h2C0, 32'h2000, 32'hB000, 1'b1);
      run_ret(32'h1F0, 32'h340, 32'h0000_0380, 32'h0000_9000, 1'b1);
      repeat (8) @(negedge clk);
      #1;
      check(!busy, "R8 no sequence started by ignored request", {31'd0, busy}, 32'd0);

      // R9: alignment faults and choice of base pointer
      dly = 0;
      run_fault(2'd0, 32'h202, 32'h300);
      run_fault(2'd1, 32'h201, 32'h300);
      run_fault(2'd2, 32'h203, 32'h300);
      run_fault(2'd3, 32'h200, 32'h302);
      run_call(2'd0, 32'h240, 32'h301, 32'h3000, 32'hC000, 1'b0);
      run_ret(32'h203, 32'h320, 32'h0000_0360, 32'h0000_7000, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule